// File: doc/BRIEF.md
# Four-Channel Priority DMA Engine

This block moves data between memory locations without processor involvement. It has four channels. Each channel keeps a source address, a destination address, a unit count and a set of control bits, and all of these are loaded through a write-only register port. All four channels share one bus master port. On every bus step, exactly one unit moves, and it always belongs to the lowest-numbered channel that is currently active. Arbitration runs again before every unit, so a channel with higher priority can take the bus from a lower one between two units.

A channel can start in one of three ways: at once, when software enables it; on a vertical or horizontal blanking event pulse; or, on channels 1 and 2 only, on a request from a sound FIFO. In FIFO mode the channel moves a burst of four 32-bit units into a fixed destination. While any channel is active, the engine holds the processor in a stall. The processor only advances after the DMA work is done.

When a channel finishes, it can raise a one-cycle interrupt pulse. A channel with repeat set stays armed for its next trigger. Any other channel switches itself off.

Top module: `dma4_engine`

## Requirements
- R1: After reset, no channel is active, `cpu_stall` and `bus_valid` are low, and every `irq` bit is low.
- R2: Writing the count/control word of a channel changes its state as follows:
  - When the write sets the enable bit (data bit 31) from 0 to 1 and the timing field (data bits 23:22) is 00, the channel becomes active in the next cycle.
  - The channel's working source, destination and remaining count are reloaded from its registers at that moment.
  - `cpu_stall` is high in every cycle in which any channel is active.
- R3: `bus_valid` is high when any channel is active. `bus_chan` then names the lowest-numbered active channel. A channel that becomes active during a lower-priority transfer takes over from the next unit.
- R4: After each unit, each address moves according to its own 2-bit adjust field (source: data bits 19:18, destination: data bits 17:16):
  - 00 or 11: increment.
  - 01: decrement.
  - 10: fixed.
  - The step is 2 bytes for 16-bit units and 4 bytes for 32-bit units. Unit width is set by data bit 21 (1 = 32-bit), which also drives `bus_wide`.
- R5: A channel moves exactly as many units as its 16-bit count field (data bits 15:0) says, then goes inactive. A count of zero moves 65536 units.
- R6: When the last unit of a run moves:
  - If the interrupt-enable bit (data bit 24) is set, `irq` of that channel is high for exactly one cycle. If the bit is clear, `irq` stays low.
  - If repeat is not in effect, the enable bit clears. A later write with enable set therefore starts a fresh transfer from the register addresses.
- R7: Repeat applies when the repeat bit (data bit 20) is set and the timing is not 00. At the end of a run:
  - The count reloads and the channel stays enabled, waiting for its next trigger.
  - The source address carries on from where it stopped.
  - If the destination adjust field is 11, the destination reloads from its register.
- R8: Timing 01 waits for a `vblank_evt` pulse and timing 10 waits for an `hblank_evt` pulse. An enabled channel that is waiting stays inactive on any other event.
- R9: FIFO mode applies on channel 1 with timing 11 (`fifo_req[0]`) and on channel 2 with timing 11 (`fifo_req[1]`). In FIFO mode:
  - Each request moves four units.
  - The units are always 32-bit.
  - The destination stays fixed whatever its adjust field says.
  - Channels 0 and 3 with timing 11 never start.
- R10: While `bus_ready` is low, no unit moves: addresses, count and `bus_chan` hold and the channel stays active.
- R11: The register port works as follows:
  - A write goes to channel `reg_wr_addr[3:2]`. Register index `reg_wr_addr[1:0]` selects what is written: 0 = source, 1 = destination, 2 = count/control (count in the low 16 bits, control in the upper 16 bits).
  - Writing control with the enable bit clear stops an active channel at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_addr | input | 4 | Channel (bits 3:2) and register index (bits 1:0) |
| reg_wr_data | input | 32 | Register write data |
| vblank_evt | input | 1 | Vertical blanking event pulse |
| hblank_evt | input | 1 | Horizontal blanking event pulse |
| fifo_req | input | 2 | Sound FIFO refill requests for channels 1 and 2 |
| bus_ready | input | 1 | Bus accepts the offered unit this cycle |
| bus_valid | output | 1 | A unit is offered on the bus |
| bus_chan | output | 2 | Channel owning the offered unit |
| bus_src_addr | output | 32 | Source address of the offered unit |
| bus_dst_addr | output | 32 | Destination address of the offered unit |
| bus_wide | output | 1 | Offered unit is 32-bit (else 16-bit) |
| cpu_stall | output | 1 | Processor must not execute |
| irq | output | 4 | Per-channel completion pulse |

## Verification
A register write or an event pulse is sampled on a rising edge. From the very next cycle, the channel shows up on `cpu_stall`, `bus_chan` and the bus addresses.

Each edge with `bus_ready` high moves one unit, so the n-th unit's addresses are visible n-1 cycles after the start. The cycle after the last unit shows the stall dropped and the `irq` pulse, and the cycle after that shows `irq` low again.

The bench changes inputs on the falling edge and reads outputs at the next falling edge, half a period after each rising edge. It walks through transfers one cycle at a time and compares every address against this cycle count.

// File: rtl/dma4_pkg.sv
package dma4_pkg;

  typedef enum logic [1:0] {
    ADJ_INC        = 2'b00,
    ADJ_DEC        = 2'b01,
    ADJ_FIX        = 2'b10,
    ADJ_INC_RELOAD = 2'b11
  } adj_e;

  typedef enum logic [1:0] {
    TIM_NOW     = 2'b00,
    TIM_VBL     = 2'b01,
    TIM_HBL     = 2'b10,
    TIM_SPECIAL = 2'b11
  } timing_e;

  // Control half of the count/control word, packed from data bits
  // {31, 24:16}; bits 30:25 carry nothing.
  typedef struct packed {
    logic    enable;
    logic    irq_en;
    timing_e timing;
    logic    wide;
    logic    repeat_en;
    adj_e    src_adj;
    adj_e    dst_adj;
  } ctl_t;

  localparam logic [1:0] IDX_SRC = 2'd0;
  localparam logic [1:0] IDX_DST = 2'd1;
  localparam logic [1:0] IDX_CTL = 2'd2;

  localparam int FIFO_UNITS = 4;

endpackage

// File: rtl/dma4_arbiter.sv
module dma4_arbiter #(
  parameter  int N  = 4,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req,
  output logic [N-1:0]  grant,
  output logic [IW-1:0] idx,
  output logic          any
);

  always_comb begin
    grant = '0;
    idx   = '0;
    any   = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (req[i] && !any) begin
        grant[i] = 1'b1;
        idx      = IW'(i);
        any      = 1'b1;
      end
    end
  end

endmodule

// File: rtl/dma4_channel.sv
module dma4_channel
  import dma4_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int CNT_W    = 16,
  parameter bit FIFO_CAP = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_idx,
  input  logic [31:0]       wr_data,
  input  logic              trig_vbl,
  input  logic              trig_hbl,
  input  logic              fifo_req,
  input  logic              unit_go,
  output logic              active,
  output logic [ADDR_W-1:0] src_addr,
  output logic [ADDR_W-1:0] dst_addr,
  output logic              wide,
  output logic              irq
);

  localparam int REM_W = CNT_W + 1;

  logic [ADDR_W-1:0] reg_src_q, reg_src_d;
  logic [ADDR_W-1:0] reg_dst_q, reg_dst_d;
  logic [CNT_W-1:0]  reg_cnt_q, reg_cnt_d;
  ctl_t              ctl_q, ctl_d;
  logic [ADDR_W-1:0] cur_src_q, cur_src_d;
  logic [ADDR_W-1:0] cur_dst_q, cur_dst_d;
  logic [REM_W-1:0]  remain_q, remain_d;
  logic              active_q, active_d;
  logic              irq_q, irq_d;

  ctl_t             new_ctl;
  logic [CNT_W-1:0] new_cnt;
  logic             ctl_wr;
  logic             enable_rise;
  logic             is_fifo;
  logic             wide_eff;
  logic [3:0]       step_bytes;
  logic             trig_hit;
  logic             fifo_hit;
  logic             last_unit;
  logic             ctl_bits_unused;

  function automatic logic fifo_mode(input ctl_t c);
    return FIFO_CAP && (c.timing == TIM_SPECIAL);
  endfunction

  function automatic logic [ADDR_W-1:0] next_addr(input logic [ADDR_W-1:0] a,
                                                  input adj_e adj,
                                                  input logic [3:0] bytes);
    case (adj)
      ADJ_DEC: return a - ADDR_W'(bytes);
      ADJ_FIX: return a;
      default: return a + ADDR_W'(bytes);
    endcase
  endfunction

  function automatic logic [REM_W-1:0] load_len(input logic [CNT_W-1:0] c,
                                                input logic f);
    if (f)
      return REM_W'(FIFO_UNITS);
    else if (c == '0)
      return REM_W'(1) << CNT_W;
    else
      return {1'b0, c};
  endfunction

  assign new_ctl         = ctl_t'({wr_data[31], wr_data[24:16]});
  assign new_cnt         = wr_data[CNT_W-1:0];
  assign ctl_bits_unused = ^wr_data[30:25];
  assign ctl_wr          = wr_en && (wr_idx == IDX_CTL);
  assign enable_rise     = ctl_wr && new_ctl.enable && !ctl_q.enable;

  assign is_fifo    = fifo_mode(ctl_q);
  assign wide_eff   = ctl_q.wide | is_fifo;
  assign step_bytes = wide_eff ? 4'd4 : 4'd2;
  assign fifo_hit   = fifo_req & FIFO_CAP;
  assign last_unit  = (remain_q == REM_W'(1));

  always_comb begin
    case (ctl_q.timing)
      TIM_VBL:     trig_hit = trig_vbl;
      TIM_HBL:     trig_hit = trig_hbl;
      TIM_SPECIAL: trig_hit = fifo_hit;
      default:     trig_hit = 1'b0;
    endcase
  end

  // Next-state logic
  always_comb begin
    reg_src_d = reg_src_q;
    reg_dst_d = reg_dst_q;
    reg_cnt_d = reg_cnt_q;
    ctl_d     = ctl_q;
    cur_src_d = cur_src_q;
    cur_dst_d = cur_dst_q;
    remain_d  = remain_q;
    active_d  = active_q;
    irq_d     = 1'b0;

    if (wr_en) begin
      case (wr_idx)
        IDX_SRC: reg_src_d = wr_data[ADDR_W-1:0];
        IDX_DST: reg_dst_d = wr_data[ADDR_W-1:0];
        IDX_CTL: begin
          reg_cnt_d = new_cnt;
          ctl_d     = new_ctl;
        end
        default: ;
      endcase
    end

    if (ctl_wr && !new_ctl.enable) begin
      active_d = 1'b0;
    end else if (enable_rise) begin
      cur_src_d = reg_src_q;
      cur_dst_d = reg_dst_q;
      remain_d  = load_len(new_cnt, fifo_mode(new_ctl));
      active_d  = (new_ctl.timing == TIM_NOW);
    end else if (active_q && unit_go) begin
      cur_src_d = next_addr(cur_src_q, ctl_q.src_adj, step_bytes);
      cur_dst_d = is_fifo ? cur_dst_q
                          : next_addr(cur_dst_q, ctl_q.dst_adj, step_bytes);
      remain_d  = remain_q - REM_W'(1);
      if (last_unit) begin
        active_d = 1'b0;
        irq_d    = ctl_q.irq_en;
        if (ctl_q.repeat_en && (ctl_q.timing != TIM_NOW)) begin
          remain_d = load_len(reg_cnt_q, is_fifo);
          if (!is_fifo && (ctl_q.dst_adj == ADJ_INC_RELOAD))
            cur_dst_d = reg_dst_q;
        end else begin
          ctl_d.enable = 1'b0;
        end
      end
    end else if (ctl_q.enable && !active_q && trig_hit) begin
      active_d = 1'b1;
    end
  end

  // State registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reg_src_q <= '0;
      reg_dst_q <= '0;
      reg_cnt_q <= '0;
      ctl_q     <= '0;
      cur_src_q <= '0;
      cur_dst_q <= '0;
      remain_q  <= '0;
      active_q  <= 1'b0;
      irq_q     <= 1'b0;
    end else begin
      reg_src_q <= reg_src_d;
      reg_dst_q <= reg_dst_d;
      reg_cnt_q <= reg_cnt_d;
      ctl_q     <= ctl_d;
      cur_src_q <= cur_src_d;
      cur_dst_q <= cur_dst_d;
      remain_q  <= remain_d;
      active_q  <= active_d;
      irq_q     <= irq_d;
    end
  end

  assign active   = active_q;
  assign src_addr = cur_src_q;
  assign dst_addr = cur_dst_q;
  assign wide     = wide_eff;
  assign irq      = irq_q;

  // R2: an immediate-timing enable starts the channel on the next cycle
  assert_start_now_R2: assert property (@(posedge clk) disable iff (!rst_n)
    enable_rise && (new_ctl.timing == TIM_NOW) |=> active_q)
    else $error("immediate enable did not start channel");

  // R6: completion pulse lasts one cycle
  assert_irq_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |=> !irq_q)
    else $error("irq longer than one cycle");

  // R8: a waiting channel stays idle without its trigger or a write
  assert_wait_trigger_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !active_q && !trig_hit && !wr_en |=> !active_q)
    else $error("channel started without trigger");

  // R9: FIFO-mode destination never moves
  assert_fifo_dst_fixed_R9: assert property (@(posedge clk) disable iff (!rst_n)
    active_q && unit_go && is_fifo && !wr_en |=> $stable(cur_dst_q))
    else $error("fifo destination moved");

  // R10: no unit, no address change
  assert_hold_no_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
    active_q && !unit_go && !wr_en |=> $stable(cur_src_q) && $stable(cur_dst_q)
                                       && $stable(remain_q))
    else $error("channel state moved without a bus step");

endmodule

// File: rtl/dma4_engine.sv
module dma4_engine
  import dma4_pkg::*;
#(
  parameter  int NUM_CH = 4,
  parameter  int ADDR_W = 32,
  parameter  int CNT_W  = 16,
  localparam int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int RA_W   = CH_W + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr_en,
  input  logic [RA_W-1:0]   reg_wr_addr,
  input  logic [31:0]       reg_wr_data,
  input  logic              vblank_evt,
  input  logic              hblank_evt,
  input  logic [1:0]        fifo_req,
  input  logic              bus_ready,
  output logic              bus_valid,
  output logic [CH_W-1:0]   bus_chan,
  output logic [ADDR_W-1:0] bus_src_addr,
  output logic [ADDR_W-1:0] bus_dst_addr,
  output logic              bus_wide,
  output logic              cpu_stall,
  output logic [NUM_CH-1:0] irq
);

  localparam logic [NUM_CH-1:0] ONE = NUM_CH'(1);

  logic [NUM_CH-1:0] ch_active;
  logic [NUM_CH-1:0] ch_grant;
  logic [NUM_CH-1:0] ch_wide;
  logic [ADDR_W-1:0] ch_src [NUM_CH];
  logic [ADDR_W-1:0] ch_dst [NUM_CH];

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    localparam bit HAS_FIFO = (g == 1) || (g == 2);
    logic ch_fifo_req;
    logic ch_wr_en;

    if (g == 1) begin : g_f1
      assign ch_fifo_req = fifo_req[0];
    end else if (g == 2) begin : g_f2
      assign ch_fifo_req = fifo_req[1];
    end else begin : g_fn
      assign ch_fifo_req = 1'b0;
    end

    assign ch_wr_en = reg_wr_en && (reg_wr_addr[RA_W-1:2] == CH_W'(g));

    dma4_channel #(
      .ADDR_W  (ADDR_W),
      .CNT_W   (CNT_W),
      .FIFO_CAP(HAS_FIFO)
    ) i_chan (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (ch_wr_en),
      .wr_idx  (reg_wr_addr[1:0]),
      .wr_data (reg_wr_data),
      .trig_vbl(vblank_evt),
      .trig_hbl(hblank_evt),
      .fifo_req(ch_fifo_req),
      .unit_go (ch_grant[g] & bus_ready),
      .active  (ch_active[g]),
      .src_addr(ch_src[g]),
      .dst_addr(ch_dst[g]),
      .wide    (ch_wide[g]),
      .irq     (irq[g])
    );
  end

  dma4_arbiter #(.N(NUM_CH)) i_arb (
    .req  (ch_active),
    .grant(ch_grant),
    .idx  (bus_chan),
    .any  (bus_valid)
  );

  always_comb begin
    bus_src_addr = '0;
    bus_dst_addr = '0;
    bus_wide     = 1'b0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (ch_grant[i]) begin
        bus_src_addr = ch_src[i];
        bus_dst_addr = ch_dst[i];
        bus_wide     = ch_wide[i];
      end
    end
  end

  assign cpu_stall = |ch_active;

  // R3: the offered channel is active and no lower-numbered one is
  assert_lowest_wins_R3: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid |-> ch_active[bus_chan] &&
                  ((ch_active & ((ONE << bus_chan) - ONE)) == '0))
    else $error("bus granted out of priority order");

  // R3: at most one grant
  assert_one_grant_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ch_grant))
    else $error("multiple grants");

  // R2: a stall cannot end while the bus is held off and nothing is written
  assert_stall_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_stall && !bus_ready && !reg_wr_en |=> cpu_stall)
    else $error("stall dropped without a unit moving");

endmodule

// File: tb/test_dma4_engine.sv
module test_dma4_engine;

  localparam int CLK_PERIOD = 10;

  logic        clk;
  logic        rst_n;
  logic        reg_wr_en;
  logic [3:0]  reg_wr_addr;
  logic [31:0] reg_wr_data;
  logic        vblank_evt;
  logic        hblank_evt;
  logic [1:0]  fifo_req;
  logic        bus_ready;
  logic        bus_valid;
  logic [1:0]  bus_chan;
  logic [31:0] bus_src_addr;
  logic [31:0] bus_dst_addr;
  logic        bus_wide;
  logic        cpu_stall;
  logic [3:0]  irq;

  int n_checks = 0;
  int n_err    = 0;

  dma4_engine i_dma4_engine (
    .clk         (clk),
    .rst_n       (rst_n),
    .reg_wr_en   (reg_wr_en),
    .reg_wr_addr (reg_wr_addr),
    .reg_wr_data (reg_wr_data),
    .vblank_evt  (vblank_evt),
    .hblank_evt  (hblank_evt),
    .fifo_req    (fifo_req),
    .bus_ready   (bus_ready),
    .bus_valid   (bus_valid),
    .bus_chan    (bus_chan),
    .bus_src_addr(bus_src_addr),
    .bus_dst_addr(bus_dst_addr),
    .bus_wide    (bus_wide),
    .cpu_stall   (cpu_stall),
    .irq         (irq)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  // Called at a falling edge; write lands on the next rising edge.
  task automatic wr(input int ch, input int idx, input logic [31:0] data);
    reg_wr_en   = 1'b1;
    reg_wr_addr = 4'(ch * 4 + idx);
    reg_wr_data = data;
    @(negedge clk);
    reg_wr_en   = 1'b0;
  endtask

  task automatic pulse(input logic vb, input logic hb, input logic [1:0] fr);
    vblank_evt = vb;
    hblank_evt = hb;
    fifo_req   = fr;
    @(negedge clk);
    vblank_evt = 1'b0;
    hblank_evt = 1'b0;
    fifo_req   = 2'b00;
  endtask

  // Check the offered unit in this cycle, then advance one cycle.
  task automatic unit(input string req, input int ch, input logic [31:0] s,
                      input logic [31:0] d, input logic w);
    chk(req, "bus_valid", 32'(bus_valid), 32'd1);
    chk(req, "bus_chan", 32'(bus_chan), 32'(ch));
    chk(req, "src", bus_src_addr, s);
    chk(req, "dst", bus_dst_addr, d);
    chk(req, "wide", 32'(bus_wide), 32'(w));
    @(negedge clk);
  endtask

  task automatic t_reset;
    chk("R1", "cpu_stall", 32'(cpu_stall), 32'd0);
    chk("R1", "bus_valid", 32'(bus_valid), 32'd0);
    chk("R1", "irq", 32'(irq), 32'd0);
  endtask

  task automatic t_immediate;
    wr(3, 0, 32'h10);
    wr(3, 1, 32'h80);
    wr(3, 2, 32'h8100_0003);  // enable, irq_en, 16-bit, inc/inc, now
    chk("R2", "stall after enable", 32'(cpu_stall), 32'd1);
    unit("R4", 3, 32'h10, 32'h80, 1'b0);
    unit("R4", 3, 32'h12, 32'h82, 1'b0);
    unit("R5", 3, 32'h14, 32'h84, 1'b0);
    chk("R5", "stall after count", 32'(cpu_stall), 32'd0);
    chk("R6", "irq pulse", 32'(irq), 32'h8);
    @(negedge clk);
    chk("R6", "irq one cycle", 32'(irq), 32'h0);
    // enable was cleared, so enabling again reloads from registers
    wr(3, 2, 32'h8000_0001);
    unit("R6", 3, 32'h10, 32'h80, 1'b0);
    chk("R6", "restart done", 32'(cpu_stall), 32'd0);
    chk("R6", "no irq when disabled", 32'(irq), 32'h0);
  endtask

  task automatic t_dec_fixed;
    wr(2, 0, 32'h2000);
    wr(2, 1, 32'h3000);
    wr(2, 2, 32'h8026_0002);  // wide, src dec, dst fixed, now, no irq
    unit("R4", 2, 32'h2000, 32'h3000, 1'b1);
    unit("R4", 2, 32'h1FFC, 32'h3000, 1'b1);
    chk("R5", "stall end", 32'(cpu_stall), 32'd0);
    chk("R6", "irq off", 32'(irq), 32'h0);
  endtask

  task automatic t_priority;
    wr(0, 0, 32'h40);
    wr(0, 1, 32'h60);
    wr(3, 0, 32'h300);
    wr(3, 1, 32'h380);
    wr(3, 2, 32'h8000_0005);
    unit("R3", 3, 32'h300, 32'h380, 1'b0);
    chk("R3", "chan before preempt", 32'(bus_chan), 32'd3);
    chk("R3", "src before preempt", bus_src_addr, 32'h302);
    wr(0, 2, 32'h8000_0002);  // ch3 moves its 2nd unit on this edge
    unit("R3", 0, 32'h40, 32'h60, 1'b0);
    unit("R3", 0, 32'h42, 32'h62, 1'b0);
    unit("R3", 3, 32'h304, 32'h384, 1'b0);
    unit("R3", 3, 32'h306, 32'h386, 1'b0);
    unit("R3", 3, 32'h308, 32'h388, 1'b0);
    chk("R3", "all done", 32'(cpu_stall), 32'd0);
  endtask

  task automatic t_ready_low;
    wr(3, 0, 32'h10);
    wr(3, 1, 32'h80);
    wr(3, 2, 32'h8000_0002);
    bus_ready = 1'b0;
    @(negedge clk);
    chk("R10", "hold src", bus_src_addr, 32'h10);
    chk("R10", "hold stall", 32'(cpu_stall), 32'd1);
    @(negedge clk);
    chk("R10", "hold src 2", bus_src_addr, 32'h10);
    bus_ready = 1'b1;
    unit("R10", 3, 32'h10, 32'h80, 1'b0);
    unit("R10", 3, 32'h12, 32'h82, 1'b0);
    chk("R10", "done", 32'(cpu_stall), 32'd0);
  endtask

  task automatic t_blank;
    wr(1, 0, 32'h100);
    wr(1, 1, 32'h200);
    wr(1, 2, 32'h8153_0002);  // enable, irq, vblank, repeat, dst inc+reload
    chk("R8", "waiting", 32'(cpu_stall), 32'd0);
    pulse(1'b0, 1'b1, 2'b00);
    chk("R8", "hblank ignored", 32'(cpu_stall), 32'd0);
    pulse(1'b1, 1'b0, 2'b00);
    unit("R8", 1, 32'h100, 32'h200, 1'b0);
    unit("R8", 1, 32'h102, 32'h202, 1'b0);
    chk("R7", "idle after run", 32'(cpu_stall), 32'd0);
    chk("R7", "irq", 32'(irq), 32'h2);
    pulse(1'b1, 1'b0, 2'b00);
    unit("R7", 1, 32'h104, 32'h200, 1'b0);
    unit("R7", 1, 32'h106, 32'h202, 1'b0);
    chk("R7", "second run done", 32'(cpu_stall), 32'd0);
    wr(1, 2, 32'h0);
  endtask

  task automatic t_fifo;
    wr(2, 0, 32'h1000);
    wr(2, 1, 32'h4000);
    wr(2, 2, 32'h80D0_0001);  // enable, fifo timing, repeat, 16-bit field
    chk("R9", "waiting", 32'(cpu_stall), 32'd0);
    pulse(1'b0, 1'b0, 2'b01);
    chk("R9", "other fifo ignored", 32'(cpu_stall), 32'd0);
    pulse(1'b0, 1'b0, 2'b10);
    for (int k = 0; k < 4; k++) unit("R9", 2, 32'h1000 + 32'(4 * k), 32'h4000, 1'b1);
    chk("R9", "burst done", 32'(cpu_stall), 32'd0);
    pulse(1'b0, 1'b0, 2'b10);
    for (int k = 0; k < 4; k++) unit("R9", 2, 32'h1010 + 32'(4 * k), 32'h4000, 1'b1);
    chk("R9", "burst 2 done", 32'(cpu_stall), 32'd0);
    wr(2, 2, 32'h0);
    wr(0, 2, 32'h80C0_0001);  // ch0 with timing 11 must never start
    pulse(1'b1, 1'b1, 2'b11);
    chk("R9", "ch0 special idle", 32'(cpu_stall), 32'd0);
    wr(0, 2, 32'h0);
  endtask

  task automatic t_abort;
    wr(3, 0, 32'h10);
    wr(3, 2, 32'h8000_000A);
    chk("R11", "running", 32'(cpu_stall), 32'd1);
    wr(3, 2, 32'h0000_000A);
    chk("R11", "stopped", 32'(cpu_stall), 32'd0);
    chk("R11", "bus idle", 32'(bus_valid), 32'd0);
  endtask

  task automatic t_count_zero;
    int units = 0;
    wr(0, 0, 32'h0);
    wr(0, 2, 32'h8000_0000);
    for (int k = 0; k < 70000 && cpu_stall; k++) begin
      units++;
      @(negedge clk);
    end
    chk("R5", "units for count zero", 32'(units), 32'd65536);
  endtask

  initial begin
    rst_n       = 1'b0;
    reg_wr_en   = 1'b0;
    reg_wr_addr = '0;
    reg_wr_data = '0;
    vblank_evt  = 1'b0;
    hblank_evt  = 1'b0;
    fifo_req    = 2'b00;
    bus_ready   = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_immediate();
    t_dec_fixed();
    t_priority();
    t_ready_low();
    t_blank();
    t_fifo();
    t_abort();
    t_count_zero();
    $display("CHECKS %0d ERRORS %0d", n_checks, n_err);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    n_checks++;
    n_err++;
    $display("FAIL watchdog run did not finish actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", n_checks, n_err);
    $finish;
  end

endmodule